// File: doc/BRIEF.md
# Pipeline Interlock for an In-Order Pipeline with a Multicycle FP Adder

This block decides, every cycle, whether the instruction sitting in decode may move on. It is meant for an in-order load/store pipeline with two execution paths. One path is a single-cycle integer execute stage. The other is a four-stage floating-point add pipeline, with stages numbered 0 to 3. Both paths drain into one shared data-memory stage and then into writeback.

The block keeps its own compact record of every instruction in flight: which stage it occupies, whether it writes a register, which register file and index it writes, and whether it is a load. When the decode instruction cannot proceed, the block raises a hold for fetch and decode and a bubble request for the next stage, and reports the cause. For every instruction it accepts, it produces registered forwarding selects for the two execute operands and for the store-data path. Those selects are valid during that instruction's first execute cycle.

Stalls come from three sources. The first is an integer load feeding the next instruction. The second is a read-after-write on an FP add result that is not ready yet. The third is a clash for the single memory stage with an FP add leaving the adder.

Top module: `pipe_interlock`

## Requirements
- R1: After synchronous reset, no instruction is in flight. `hold_front`, `insert_bubble` and `stall_cause` are 0, and all forwarding selects are 0.
- R2: An integer ALU op followed directly by an integer store (class 2) whose data register (rs2) is the ALU's destination is accepted without a stall. The store's `fwd_sd` reads 1 (memory-stage result) in its execute cycle.
- R3: A load (class 1) followed directly by an integer ALU op (class 0) reading the loaded register stalls exactly one cycle with cause 1. The consumer's operand select then reads 2 (writeback-stage result).
- R4: An FP add (class 3) followed directly by an FP store (class 4) whose data register is the add's destination stalls three cycles. The causes are 2, 2, 3 in that order (2 = FP data not ready, 3 = memory-stage conflict). `fwd_sd` then reads 1.
- R5: Any instruction other than an FP add that sits in decode while an FP add occupies adder stage 2 stalls with cause 3. At no time do the integer execute stage and adder stage 3 both hold an instruction.
- R6: An FP add followed directly by an FP add reading its result stalls three cycles, each with cause 2. The consumer's select then reads 1.
- R7: Integer register 0 is never a dependency. A load writing register 0 followed by an ALU op reading register 0 gives no stall and selects 0.
- R8: Integer and FP register indices are separate. An FP add writing FP register n never stalls or forwards to a reader of integer register n, and the reverse also holds.
- R9: Forwarding picks the youngest producer. A producer one stage ahead of the consumer gives select 1, even when an older producer of the same register is in the memory stage. A producer two stages ahead gives 2. A producer further back gives 0 (register file).
- R10: A load followed directly by an integer store whose data register is the loaded register stalls one cycle with cause 1. `fwd_sd` then reads 2.
- R11: `insert_bubble` equals `hold_front`. In the cycle after any stall cycle, all forwarding selects read 0, because a bubble entered execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_cls | input | 3 | Class: 0 ALU, 1 load, 2 store, 3 FP add, 4 FP store |
| id_rs1 | input | RIDX_W | First source: FP for FP add, otherwise integer (address base for memory ops) |
| id_rs2 | input | RIDX_W | Second ALU operand, or store data (FP for FP store) |
| id_rd | input | RIDX_W | Destination (integer for ALU/load, FP for FP add) |
| hold_front | output | 1 | Hold fetch and decode registers |
| insert_bubble | output | 1 | Insert a no-op into the next stage |
| stall_cause | output | 2 | 0 none, 1 load-use, 2 FP data not ready, 3 memory-stage conflict |
| fwd_a | output | 2 | First operand select: 0 register file, 1 memory-stage result, 2 writeback result |
| fwd_b | output | 2 | Second ALU operand select, same codes |
| fwd_sd | output | 2 | Store-data select, same codes |

## Verification
`hold_front`, `insert_bubble` and `stall_cause` are combinational on the decode descriptor and the tracked state. The bench therefore samples them in the low phase of the same cycle the descriptor is presented, and once more for each cycle the descriptor is held. The forwarding selects are registered, so they are due one clock edge after the edge that accepts the instruction. They are read 1 ns after that edge. After each stalled edge the bench also reads them, expecting zeros for the bubble. Each scenario drains for several idle cycles so that every stall count and cause sequence is caused by the instructions of that scenario alone.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int unsigned RIDX_W = 5;

  typedef enum logic [2:0] {
    CL_ALU    = 3'd0,
    CL_LOAD   = 3'd1,
    CL_STORE  = 3'd2,
    CL_FADD   = 3'd3,
    CL_FSTORE = 3'd4
  } op_cls_e;

  typedef enum logic [1:0] {
    FW_RF  = 2'd0,
    FW_MEM = 2'd1,
    FW_WB  = 2'd2
  } fwd_e;

  typedef enum logic [1:0] {
    HC_NONE = 2'd0,
    HC_LOAD = 2'd1,
    HC_FRAW = 2'd2,
    HC_PORT = 2'd3
  } cause_e;

  // one in-flight instruction
  typedef struct packed {
    logic              occ;
    logic              wr;
    logic              is_fp;
    logic              is_load;
    logic [RIDX_W-1:0] dst;
  } flight_t;

  // one register read of the decode instruction
  typedef struct packed {
    logic              vld;
    logic              fp;
    logic [RIDX_W-1:0] idx;
  } regref_t;

  function automatic regref_t make_ref(logic used, logic fp, logic [RIDX_W-1:0] idx);
    regref_t r;
    r.vld = used && (fp || (idx != '0));
    r.fp  = fp;
    r.idx = idx;
    return r;
  endfunction

  function automatic logic hits(flight_t f, regref_t r);
    return f.occ && f.wr && r.vld && (f.is_fp == r.fp) && (f.dst == r.idx);
  endfunction
endpackage

// File: rtl/pil_track.sv
module pil_track
  import pil_pkg::*;
#(
  parameter int unsigned NST = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic                  to_fadd,
  input  flight_t               new_rec,
  output flight_t               ex_q,
  output flight_t [NST-1:0]     fa_q,
  output flight_t               mem_q,
  output flight_t               wb_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      ex_q  <= (take && !to_fadd) ? new_rec : '0;
      mem_q <= ex_q.occ ? ex_q : fa_q[NST-1];
      wb_q  <= mem_q;
    end
  end

  // adder stages keep advancing regardless of decode stalls
  for (genvar g = 0; g < NST; g++) begin : g_fa
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) fa_q[0] <= '0;
        else     fa_q[0] <= (take && to_fadd) ? new_rec : '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) fa_q[g] <= '0;
        else     fa_q[g] <= fa_q[g-1];
      end
    end
  end
endmodule

// File: rtl/pil_detect.sv
module pil_detect
  import pil_pkg::*;
#(
  parameter int unsigned NST = 4
) (
  input  logic              id_live,
  input  logic              mem_user,
  input  regref_t           src_a,
  input  regref_t           src_b,
  input  regref_t           src_s,
  input  flight_t           ex_q,
  input  flight_t [NST-1:0] fa_q,
  output logic              stall,
  output cause_e            cause
);
  logic load_use, fraw, port;

  always_comb begin
    load_use = ex_q.is_load &&
               (hits(ex_q, src_a) || hits(ex_q, src_b) || hits(ex_q, src_s));
    fraw = 1'b0;
    for (int i = 0; i < int'(NST); i++) begin
      // operands are needed at adder entry: result must be in the last stage
      if (i <= int'(NST) - 2 && (hits(fa_q[i], src_a) || hits(fa_q[i], src_b)))
        fraw = 1'b1;
      // store data needed late: two stages from the end is a port clash instead
      if (i <= int'(NST) - 3 && hits(fa_q[i], src_s))
        fraw = 1'b1;
    end
    port = mem_user && fa_q[NST-2].occ;

    stall = id_live && (load_use || fraw || port);
    if (!id_live)      cause = HC_NONE;
    else if (load_use) cause = HC_LOAD;
    else if (fraw)     cause = HC_FRAW;
    else if (port)     cause = HC_PORT;
    else               cause = HC_NONE;
  end
endmodule

// File: rtl/pil_fwd.sv
module pil_fwd
  import pil_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    take,
  input  regref_t src_a,
  input  regref_t src_b,
  input  regref_t src_s,
  input  flight_t ex_q,
  input  flight_t fa_last,
  input  flight_t mem_q,
  output fwd_e    sel_a,
  output fwd_e    sel_b,
  output fwd_e    sel_s
);
  function automatic fwd_e pick(regref_t r, flight_t ex, flight_t fl, flight_t mm);
    if (hits(ex, r) || hits(fl, r)) return FW_MEM;
    if (hits(mm, r))                return FW_WB;
    return FW_RF;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !take) begin
      sel_a <= FW_RF;
      sel_b <= FW_RF;
      sel_s <= FW_RF;
    end else begin
      sel_a <= pick(src_a, ex_q, fa_last, mem_q);
      sel_b <= pick(src_b, ex_q, fa_last, mem_q);
      sel_s <= pick(src_s, ex_q, fa_last, mem_q);
    end
  end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pil_pkg::*;
#(
  parameter int unsigned FADD_STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [2:0]        id_cls,
  input  logic [RIDX_W-1:0] id_rs1,
  input  logic [RIDX_W-1:0] id_rs2,
  input  logic [RIDX_W-1:0] id_rd,
  output logic              hold_front,
  output logic              insert_bubble,
  output logic [1:0]        stall_cause,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic [1:0]        fwd_sd
);
  op_cls_e cls;
  logic    known, id_live, is_fadd, mem_user, stall, take;
  regref_t src_a, src_b, src_s;
  flight_t new_rec;
  flight_t ex_q, mem_q, wb_q;
  flight_t [FADD_STAGES-1:0] fa_q;
  cause_e  cause;
  fwd_e    sel_a, sel_b, sel_s;

  always_comb begin
    cls      = op_cls_e'(id_cls);
    known    = (id_cls <= 3'd4);
    id_live  = id_valid && known;
    is_fadd  = (cls == CL_FADD);
    mem_user = !is_fadd;
    src_a    = make_ref(known, is_fadd, id_rs1);
    src_b    = make_ref(cls == CL_ALU || is_fadd, is_fadd, id_rs2);
    src_s    = make_ref(cls == CL_STORE || cls == CL_FSTORE, cls == CL_FSTORE, id_rs2);
    new_rec.occ     = 1'b1;
    new_rec.wr      = (cls == CL_ALU || cls == CL_LOAD || is_fadd) &&
                      (is_fadd || id_rd != '0);
    new_rec.is_fp   = is_fadd;
    new_rec.is_load = (cls == CL_LOAD);
    new_rec.dst     = id_rd;
  end

  assign take = id_live && !stall;

  pil_track #(.NST(FADD_STAGES)) u_track (
    .clk(clk), .rst(rst), .take(take), .to_fadd(is_fadd), .new_rec(new_rec),
    .ex_q(ex_q), .fa_q(fa_q), .mem_q(mem_q), .wb_q(wb_q)
  );

  pil_detect #(.NST(FADD_STAGES)) u_detect (
    .id_live(id_live), .mem_user(mem_user), .src_a(src_a), .src_b(src_b),
    .src_s(src_s), .ex_q(ex_q), .fa_q(fa_q), .stall(stall), .cause(cause)
  );

  pil_fwd u_fwd (
    .clk(clk), .rst(rst), .take(take), .src_a(src_a), .src_b(src_b),
    .src_s(src_s), .ex_q(ex_q), .fa_last(fa_q[FADD_STAGES-1]), .mem_q(mem_q),
    .sel_a(sel_a), .sel_b(sel_b), .sel_s(sel_s)
  );

  assign hold_front    = stall;
  assign insert_bubble = stall;
  assign stall_cause   = cause;
  assign fwd_a         = sel_a;
  assign fwd_b         = sel_b;
  assign fwd_sd        = sel_s;
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold_front,
  input logic [1:0] stall_cause,
  input logic [1:0] fwd_a,
  input logic [1:0] fwd_b,
  input logic [1:0] fwd_sd,
  input logic       id_valid,
  input logic [2:0] id_cls,
  input logic [4:0] id_rs1,
  input logic       ex_occ,
  input logic       a3_occ
);
  // R5: memory stage is fed by one path at a time
  p_single_mem_r5: assert property (@(posedge clk) disable iff (rst)
    !(ex_occ && a3_occ));

  // R3: a load-use stall never repeats in the next cycle
  p_load_use_once_r3: assert property (@(posedge clk) disable iff (rst)
    (stall_cause == 2'd1) |=> (stall_cause != 2'd1));

  // R11: a stalled cycle sends a bubble, so selects clear
  p_bubble_clears_r11: assert property (@(posedge clk) disable iff (rst)
    hold_front |=> (fwd_a == 2'd0 && fwd_b == 2'd0 && fwd_sd == 2'd0));

  // R7: integer register 0 is never forwarded
  p_no_r0_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    (id_valid && !hold_front && id_rs1 == 5'd0 && id_cls != 3'd3 && id_cls <= 3'd4)
      |=> (fwd_a == 2'd0));

  // R9: code 3 is never produced
  p_fwd_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'd3) && (fwd_b != 2'd3) && (fwd_sd != 2'd3));
endmodule

bind pipe_interlock pipe_interlock_chk u_chk (
  .clk(clk), .rst(rst), .hold_front(hold_front), .stall_cause(stall_cause),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd), .id_valid(id_valid),
  .id_cls(id_cls), .id_rs1(id_rs1), .ex_occ(ex_q.occ),
  .a3_occ(fa_q[FADD_STAGES-1].occ)
);

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       id_valid = 1'b0;
  logic [2:0] id_cls = 3'd0;
  logic [4:0] id_rs1 = 5'd0, id_rs2 = 5'd0, id_rd = 5'd0;
  logic       hold_front, insert_bubble;
  logic [1:0] stall_cause, fwd_a, fwd_b, fwd_sd;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [2:0] ALU = 3'd0, LD = 3'd1, ST = 3'd2, FA = 3'd3, FS = 3'd4;

  always #10 clk = ~clk;

  pipe_interlock u_pipe_interlock (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_cls(id_cls),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
    .hold_front(hold_front), .insert_bubble(insert_bubble),
    .stall_cause(stall_cause), .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // results of the last send
  int         n_st;
  logic [1:0] cz [4];
  logic [1:0] ra, rb, rs;
  bit         bub_ok, bub_eq;

  // present one instruction at a negedge; hold while stalled
  task automatic send(input logic [2:0] c, input logic [4:0] s1, input logic [4:0] s2,
                      input logic [4:0] d);
    bit s;
    id_valid = 1'b1; id_cls = c; id_rs1 = s1; id_rs2 = s2; id_rd = d;
    n_st = 0; bub_ok = 1'b1; bub_eq = 1'b1;
    for (int k = 0; k < 4; k++) cz[k] = 2'd0;
    forever begin
      #5;
      s = hold_front;
      if (insert_bubble != hold_front) bub_eq = 1'b0;
      if (s && n_st < 4) cz[n_st] = stall_cause;
      @(posedge clk); #1;
      if (!s) break;
      n_st++;
      if (fwd_a != 0 || fwd_b != 0 || fwd_sd != 0) bub_ok = 1'b0;
      if (n_st > 8) break;
    end
    ra = fwd_a; rb = fwd_b; rs = fwd_sd;
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    id_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!hold_front && !insert_bubble, "R1 no hold after reset", hold_front, 0);
    chk(stall_cause == 0, "R1 cause after reset", stall_cause, 0);
    chk(fwd_a == 0 && fwd_b == 0 && fwd_sd == 0, "R1 selects after reset",
        {fwd_a, fwd_b, fwd_sd}, 0);
  endtask

  task automatic t_alu_store;
    send(ALU, 5'd1, 5'd2, 5'd3);
    send(ST, 5'd4, 5'd3, 5'd0);
    chk(n_st == 0, "R2 alu->store no stall", n_st, 0);
    chk(rs == 1, "R2 store data from memory stage", rs, 1);
    chk(ra == 0, "R2 base from regfile", ra, 0);
    idle(8);
  endtask

  task automatic t_load_use;
    send(LD, 5'd1, 5'd0, 5'd6);
    send(ALU, 5'd6, 5'd2, 5'd7);
    chk(n_st == 1, "R3 load-use stall count", n_st, 1);
    chk(cz[0] == 1, "R3 load-use cause", cz[0], 1);
    chk(ra == 2, "R3 operand from writeback", ra, 2);
    chk(bub_ok, "R11 selects clear after stall", bub_ok, 1);
    chk(bub_eq, "R11 bubble equals hold", bub_eq, 1);
    idle(8);
  endtask

  task automatic t_load_store;
    send(LD, 5'd1, 5'd0, 5'd8);
    send(ST, 5'd2, 5'd8, 5'd0);
    chk(n_st == 1, "R10 load->store data stall count", n_st, 1);
    chk(cz[0] == 1, "R10 cause", cz[0], 1);
    chk(rs == 2, "R10 store data from writeback", rs, 2);
    idle(8);
  endtask

  task automatic t_fadd_fstore;
    send(FA, 5'd1, 5'd2, 5'd3);
    send(FS, 5'd1, 5'd3, 5'd0);
    chk(n_st == 3, "R4 fadd->fstore stall count", n_st, 3);
    chk(cz[0] == 2, "R4 first stall data", cz[0], 2);
    chk(cz[1] == 2, "R4 second stall data", cz[1], 2);
    chk(cz[2] == 3, "R4 third stall port", cz[2], 3);
    chk(rs == 1, "R4 store data from memory stage", rs, 1);
    chk(bub_ok, "R11 selects clear during fp stalls", bub_ok, 1);
    idle(8);
  endtask

  task automatic t_fadd_fadd;
    send(FA, 5'd1, 5'd2, 5'd4);
    send(FA, 5'd4, 5'd1, 5'd5);
    chk(n_st == 3, "R6 fadd->fadd stall count", n_st, 3);
    chk(cz[0] == 2 && cz[1] == 2 && cz[2] == 2, "R6 all data stalls",
        {cz[0], cz[1], cz[2]}, 6'b101010);
    chk(ra == 1, "R6 operand from memory stage", ra, 1);
    idle(8);
  endtask

  task automatic t_port;
    send(FA, 5'd6, 5'd7, 5'd8);
    send(ALU, 5'd10, 5'd11, 5'd12);
    chk(n_st == 0, "R5 first follower free", n_st, 0);
    send(ALU, 5'd10, 5'd11, 5'd13);
    chk(n_st == 0, "R5 second follower free", n_st, 0);
    send(ALU, 5'd10, 5'd11, 5'd14);
    chk(n_st == 1, "R5 third follower port stall", n_st, 1);
    chk(cz[0] == 3, "R5 port cause", cz[0], 3);
    idle(8);
  endtask

  task automatic t_r0;
    send(LD, 5'd1, 5'd0, 5'd0);
    send(ALU, 5'd0, 5'd0, 5'd9);
    chk(n_st == 0, "R7 r0 no stall", n_st, 0);
    chk(ra == 0 && rb == 0, "R7 r0 no forward", {ra, rb}, 0);
    idle(8);
  endtask

  task automatic t_names;
    send(FA, 5'd5, 5'd5, 5'd12);
    send(ALU, 5'd12, 5'd12, 5'd13);
    chk(n_st == 0, "R8 fp dst vs int src no stall", n_st, 0);
    chk(ra == 0 && rb == 0, "R8 fp dst vs int src no forward", {ra, rb}, 0);
    idle(8);
    send(ALU, 5'd1, 5'd2, 5'd14);
    send(FA, 5'd14, 5'd14, 5'd15);
    chk(n_st == 0, "R8 int dst vs fp src no stall", n_st, 0);
    chk(ra == 0 && rb == 0, "R8 int dst vs fp src no forward", {ra, rb}, 0);
    idle(8);
  endtask

  task automatic t_prio;
    send(ALU, 5'd1, 5'd2, 5'd20);
    send(ALU, 5'd3, 5'd4, 5'd20);
    send(ALU, 5'd20, 5'd21, 5'd22);
    chk(ra == 1, "R9 youngest int producer wins", ra, 1);
    idle(8);
    send(ALU, 5'd1, 5'd2, 5'd23);
    send(ALU, 5'd3, 5'd4, 5'd24);
    send(ALU, 5'd21, 5'd23, 5'd25);
    chk(rb == 2, "R9 distance two from writeback", rb, 2);
    idle(8);
    send(ALU, 5'd1, 5'd2, 5'd26);
    send(ALU, 5'd3, 5'd4, 5'd27);
    send(ALU, 5'd3, 5'd4, 5'd28);
    send(ALU, 5'd26, 5'd4, 5'd29);
    chk(ra == 0, "R9 distance three from regfile", ra, 0);
    idle(8);
    send(FA, 5'd1, 5'd2, 5'd9);
    send(FA, 5'd3, 5'd4, 5'd9);
    send(FA, 5'd9, 5'd1, 5'd10);
    chk(n_st == 3, "R9 fp chain stall count", n_st, 3);
    chk(ra == 1, "R9 youngest fp producer wins", ra, 1);
    idle(8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    @(negedge clk);
    t_alu_store();
    t_load_use();
    t_load_store();
    t_fadd_fstore();
    t_fadd_fadd();
    t_port();
    t_r0();
    t_names();
    t_prio();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule